// File: doc/BRIEF.md
# Power-Good and Overvoltage Supervisor

This block judges a digitized converter feedback code against the active reference code and produces two independent verdicts. The power-good verdict uses a narrow entry window that must be held continuously for a long qualification time, and a wider exit window that must be violated for a full switching cycle before the verdict is withdrawn. The overvoltage verdict compares feedback against a high threshold for more than one switching cycle. It latches until feedback has come back down and a clear pulse is given.

Overvoltage detection is blanked while the reference is slewing. It is armed again only after a fixed delay that follows the end of a soft start. While an overvoltage fault is shown, the block raises a request to drop the switching frequency to a low fixed rate. Each verdict has its own mask, which suppresses both the protective effect and the indication of that source. All windows are integer fractions of the reference code. All long intervals are counted in microsecond ticks from a prescaler on the system clock.

Top module: `pgov_supervisor`

## Requirements
- R1: While reset is asserted, pg_good=0, pg_irq=1, ov_fault=0 and freq_req=0.
- R2: With pg_mask=0, pg_good rises only after fb_code has stayed continuously in the entry window [ceil(ref*(100-ENTRY_PCT)/100), floor(ref*(100+ENTRY_PCT)/100)] for PG_QUAL_US microsecond ticks. It stays 0 after one tick fewer.
- R3: Any cycle with fb_code outside the entry window restarts the qualification count from zero.
- R4: The entry-window bounds are inclusive and rounded toward the inside. With ref=333 the bounds are 317..349, so 316 and 350 never qualify and 349 does.
- R5: Once good, pg_good stays 1 while fb_code is inside the exit window [ceil(ref*(100-EXIT_PCT)/100), floor(ref*(100+EXIT_PCT)/100)]. It falls on the second sw_tick seen with fb_code continuously outside that window. A return inside restarts this count.
- R6: pg_irq is 1 exactly when pg_good is 0, including the whole startup qualification.
- R7: pg_mask=1 forces pg_good=1 and pg_irq=0. Clearing it shows the tracked status again.
- R8: When armed and with ov_mask=0, the fault sets on the second sw_tick seen with fb_code continuously above floor(ref*OV_PCT/100). A value equal to the threshold never sets it.
- R9: Detection is disarmed from reset and whenever slewing=1. It arms OV_ARM_US microsecond ticks after an ss_done pulse.
- R10: A set fault holds until an ov_clear pulse arrives while fb_code is at or below the threshold. A clear while still above has no effect.
- R11: freq_req is 1 exactly while ov_fault is 1.
- R12: ov_mask=1 blocks the setting of a fault and hides a latched one on ov_fault and freq_req. A latched fault reappears when the mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_code | input | CODE_W | Digitized feedback value |
| ref_code | input | CODE_W | Active reference code |
| sw_tick | input | 1 | One-cycle pulse per switching cycle |
| slewing | input | 1 | Reference transition in progress |
| ss_done | input | 1 | One-cycle pulse at soft-start completion |
| pg_mask | input | 1 | Mask for power-good action and indication |
| ov_mask | input | 1 | Mask for overvoltage action and indication |
| ov_clear | input | 1 | Pulse to release a latched overvoltage fault |
| pg_good | output | 1 | Power-good status |
| pg_irq | output | 1 | Interrupt request level, high while not good |
| ov_fault | output | 1 | Overvoltage fault flag |
| freq_req | output | 1 | Request for the reduced overvoltage switching frequency |

## Verification
The bench builds the block with 4 clocks per microsecond, a 20-tick power-good qualification and a 10-tick overvoltage arming delay. With these values both timers can be run to completion many times, and each can be probed one tick short of its limit. The bench drives sw_tick by hand, so the one-cycle persistence rules for exit and overvoltage are checked against an exact count of ticks. A reference of 333 puts every rounded threshold on a non-integer product, which tests the rounding of each bound.

// File: rtl/pgov_pkg.sv
package pgov_pkg;

  typedef enum logic {
    PG_QUAL = 1'b0,
    PG_GOOD = 1'b1
  } pg_state_e;

  typedef enum logic [1:0] {
    ARM_OFF  = 2'd0,
    ARM_WAIT = 2'd1,
    ARM_ON   = 2'd2
  } arm_state_e;

  // Scaled threshold rounded down: code*pct/100
  function automatic logic [31:0] pct_floor(input logic [31:0] code, input int unsigned pct);
    return (code * 32'(pct)) / 32'd100;
  endfunction

  // Scaled threshold rounded up: ceil(code*pct/100)
  function automatic logic [31:0] pct_ceil(input logic [31:0] code, input int unsigned pct);
    return ((code * 32'(pct)) + 32'd99) / 32'd100;
  endfunction

endpackage

// File: rtl/pgov_timebase.sv
module pgov_timebase #(
  parameter int unsigned CLK_PER_US = 125
) (
  input  logic clk,
  input  logic rst_n,
  output logic us_tick
);
  localparam int unsigned TW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [TW-1:0] LAST = TW'(CLK_PER_US - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    us_tick = (cnt_q == LAST);
    cnt_d   = us_tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pgov_limits.sv
module pgov_limits
  import pgov_pkg::*;
#(
  parameter int unsigned CODE_W    = 10,
  parameter int unsigned ENTRY_PCT = 5,
  parameter int unsigned EXIT_PCT  = 7,
  parameter int unsigned OV_PCT    = 115
) (
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] ref_code,
  output logic              in_entry,
  output logic              out_exit,
  output logic              over_ov
);
  localparam int unsigned ENT_HI_PCT = 100 + ENTRY_PCT;
  localparam int unsigned ENT_LO_PCT = 100 - ENTRY_PCT;
  localparam int unsigned EXT_HI_PCT = 100 + EXIT_PCT;
  localparam int unsigned EXT_LO_PCT = 100 - EXIT_PCT;

  logic [31:0] fb_w, ref_w;
  logic [31:0] ent_hi, ent_lo, ext_hi, ext_lo, ov_th;

  always_comb begin
    fb_w   = 32'(fb_code);
    ref_w  = 32'(ref_code);
    // upper bounds round down, lower bounds round up: tighter side
    ent_hi = pct_floor(ref_w, ENT_HI_PCT);
    ent_lo = pct_ceil(ref_w, ENT_LO_PCT);
    ext_hi = pct_floor(ref_w, EXT_HI_PCT);
    ext_lo = pct_ceil(ref_w, EXT_LO_PCT);
    ov_th  = pct_floor(ref_w, OV_PCT);
    in_entry = (fb_w >= ent_lo) && (fb_w <= ent_hi);
    out_exit = (fb_w < ext_lo) || (fb_w > ext_hi);
    over_ov  = (fb_w > ov_th);
  end
endmodule

// File: rtl/pgov_pg_track.sv
module pgov_pg_track
  import pgov_pkg::*;
#(
  parameter int unsigned PG_QUAL_US = 3300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic sw_tick,
  input  logic in_entry,
  input  logic out_exit,
  output logic good
);
  localparam int unsigned QW = (PG_QUAL_US > 1) ? $clog2(PG_QUAL_US) : 1;
  localparam logic [QW-1:0] QLAST = QW'(PG_QUAL_US - 1);

  pg_state_e     state_q, state_d;
  logic [QW-1:0] qcnt_q, qcnt_d;
  logic          xarm_q, xarm_d;

  always_comb begin
    state_d = state_q;
    qcnt_d  = qcnt_q;
    xarm_d  = xarm_q;
    unique case (state_q)
      PG_QUAL: begin
        xarm_d = 1'b0;
        if (!in_entry) begin
          qcnt_d = '0;
        end else if (us_tick) begin
          if (qcnt_q == QLAST) begin
            state_d = PG_GOOD;
            qcnt_d  = '0;
          end else begin
            qcnt_d = qcnt_q + 1'b1;
          end
        end
      end
      PG_GOOD: begin
        if (!out_exit) begin
          xarm_d = 1'b0;
        end else if (sw_tick) begin
          if (xarm_q) begin
            state_d = PG_QUAL;
            xarm_d  = 1'b0;
          end else begin
            xarm_d = 1'b1;
          end
        end
      end
      default: state_d = PG_QUAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_QUAL;
      qcnt_q  <= '0;
      xarm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      qcnt_q  <= qcnt_d;
      xarm_q  <= xarm_d;
    end
  end

  assign good = (state_q == PG_GOOD);
endmodule

// File: rtl/pgov_ov_guard.sv
module pgov_ov_guard
  import pgov_pkg::*;
#(
  parameter int unsigned OV_ARM_US = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic sw_tick,
  input  logic slewing,
  input  logic ss_done,
  input  logic over_ov,
  input  logic ov_mask,
  input  logic ov_clear,
  output logic fault
);
  localparam int unsigned AW = (OV_ARM_US > 1) ? $clog2(OV_ARM_US) : 1;
  localparam logic [AW-1:0] ALAST = AW'(OV_ARM_US - 1);

  arm_state_e    arm_q, arm_d;
  logic [AW-1:0] acnt_q, acnt_d;
  logic          pend_q, pend_d;
  logic          flt_q, flt_d;
  logic          set_flt;

  // arming sequencer
  always_comb begin
    arm_d  = arm_q;
    acnt_d = acnt_q;
    if (slewing) begin
      arm_d  = ARM_OFF;
      acnt_d = '0;
    end else if (ss_done) begin
      arm_d  = ARM_WAIT;
      acnt_d = '0;
    end else if (arm_q == ARM_WAIT && us_tick) begin
      if (acnt_q == ALAST) begin
        arm_d  = ARM_ON;
        acnt_d = '0;
      end else begin
        acnt_d = acnt_q + 1'b1;
      end
    end
  end

  // persistence and latch
  always_comb begin
    set_flt = 1'b0;
    pend_d  = pend_q;
    if (arm_q != ARM_ON || ov_mask || !over_ov) begin
      pend_d = 1'b0;
    end else if (sw_tick) begin
      if (pend_q) begin
        set_flt = 1'b1;
        pend_d  = 1'b0;
      end else begin
        pend_d = 1'b1;
      end
    end
    flt_d = flt_q;
    if (set_flt)                    flt_d = 1'b1;
    else if (ov_clear && !over_ov)  flt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= ARM_OFF;
      acnt_q <= '0;
      pend_q <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      acnt_q <= acnt_d;
      pend_q <= pend_d;
      flt_q  <= flt_d;
    end
  end

  assign fault = flt_q;
endmodule

// File: rtl/pgov_supervisor.sv
module pgov_supervisor #(
  parameter int unsigned CODE_W     = 10,
  parameter int unsigned CLK_PER_US = 125,
  parameter int unsigned PG_QUAL_US = 3300,
  parameter int unsigned OV_ARM_US  = 1000,
  parameter int unsigned ENTRY_PCT  = 5,
  parameter int unsigned EXIT_PCT   = 7,
  parameter int unsigned OV_PCT     = 115
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] ref_code,
  input  logic              sw_tick,
  input  logic              slewing,
  input  logic              ss_done,
  input  logic              pg_mask,
  input  logic              ov_mask,
  input  logic              ov_clear,
  output logic              pg_good,
  output logic              pg_irq,
  output logic              ov_fault,
  output logic              freq_req
);
  logic [1:0] rsync_q;
  logic       rst_ns;
  logic       us_tick, in_entry, out_exit, over_ov, good, flt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  pgov_timebase #(.CLK_PER_US(CLK_PER_US)) u_tb (
    .clk(clk), .rst_n(rst_ns), .us_tick(us_tick)
  );

  pgov_limits #(
    .CODE_W(CODE_W), .ENTRY_PCT(ENTRY_PCT), .EXIT_PCT(EXIT_PCT), .OV_PCT(OV_PCT)
  ) u_lim (
    .fb_code(fb_code), .ref_code(ref_code),
    .in_entry(in_entry), .out_exit(out_exit), .over_ov(over_ov)
  );

  pgov_pg_track #(.PG_QUAL_US(PG_QUAL_US)) u_pg (
    .clk(clk), .rst_n(rst_ns), .us_tick(us_tick), .sw_tick(sw_tick),
    .in_entry(in_entry), .out_exit(out_exit), .good(good)
  );

  pgov_ov_guard #(.OV_ARM_US(OV_ARM_US)) u_ov (
    .clk(clk), .rst_n(rst_ns), .us_tick(us_tick), .sw_tick(sw_tick),
    .slewing(slewing), .ss_done(ss_done), .over_ov(over_ov),
    .ov_mask(ov_mask), .ov_clear(ov_clear), .fault(flt)
  );

  assign pg_good  = good | pg_mask;
  assign pg_irq   = ~pg_good;
  assign ov_fault = flt & ~ov_mask;
  assign freq_req = ov_fault;
endmodule

// File: rtl/pgov_supervisor_chk.sv
module pgov_supervisor_chk
  import pgov_pkg::*;
#(
  parameter int unsigned CODE_W    = 10,
  parameter int unsigned ENTRY_PCT = 5,
  parameter int unsigned EXIT_PCT  = 7,
  parameter int unsigned OV_PCT    = 115
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] fb_code,
  input logic [CODE_W-1:0] ref_code,
  input logic              sw_tick,
  input logic              pg_mask,
  input logic              ov_mask,
  input logic              ov_clear,
  input logic              pg_good,
  input logic              pg_irq,
  input logic              ov_fault,
  input logic              freq_req
);
  logic [31:0] fbw, rfw;
  logic        c_in, c_out, c_over;

  always_comb begin
    fbw    = 32'(fb_code);
    rfw    = 32'(ref_code);
    c_in   = (fbw >= pct_ceil(rfw, 100 - ENTRY_PCT)) && (fbw <= pct_floor(rfw, 100 + ENTRY_PCT));
    c_out  = (fbw < pct_ceil(rfw, 100 - EXIT_PCT)) || (fbw > pct_floor(rfw, 100 + EXIT_PCT));
    c_over = fbw > pct_floor(rfw, OV_PCT);
  end

  p_pg_rise_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pg_good) && !pg_mask && !$past(pg_mask)) |-> $past(c_in));

  p_pg_drop_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pg_good) && !$past(pg_mask)) |-> ($past(sw_tick) && $past(c_out)));

  p_irq_not_good_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pg_irq |-> !pg_good);

  p_ov_set_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ov_fault) && !$past(ov_mask)) |-> ($past(sw_tick) && $past(c_over)));

  p_ov_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_fault && !(ov_clear && !c_over)) |=> (ov_fault || ov_mask));

  p_freq_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freq_req) |-> ov_fault);

  p_ov_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ov_mask |-> (!ov_fault && !freq_req));
endmodule

bind pgov_supervisor pgov_supervisor_chk #(
  .CODE_W(CODE_W), .ENTRY_PCT(ENTRY_PCT), .EXIT_PCT(EXIT_PCT), .OV_PCT(OV_PCT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .ref_code(ref_code),
  .sw_tick(sw_tick), .pg_mask(pg_mask), .ov_mask(ov_mask), .ov_clear(ov_clear),
  .pg_good(pg_good), .pg_irq(pg_irq), .ov_fault(ov_fault), .freq_req(freq_req)
);

// File: tb/pgov_supervisor_bench.sv
`timescale 1ns/1ps
module pgov_supervisor_bench;
  localparam int CW = 10;
  localparam int P  = 4;   // clocks per microsecond
  localparam int Q  = 20;  // qualification ticks
  localparam int A  = 10;  // arming ticks

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, sw_tick, slewing, ss_done, pg_mask, ov_mask, ov_clear;
  logic [CW-1:0] fb_code, ref_code;
  logic          pg_good, pg_irq, ov_fault, freq_req;

  pgov_supervisor #(
    .CODE_W(CW), .CLK_PER_US(P), .PG_QUAL_US(Q), .OV_ARM_US(A)
  ) u_pgov_supervisor (
    .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .ref_code(ref_code),
    .sw_tick(sw_tick), .slewing(slewing), .ss_done(ss_done),
    .pg_mask(pg_mask), .ov_mask(ov_mask), .ov_clear(ov_clear),
    .pg_good(pg_good), .pg_irq(pg_irq), .ov_fault(ov_fault), .freq_req(freq_req)
  );

  typedef struct {
    string tag;
    bit    is_ov;
    bit    ea;
    bit    eb;
  } item_t;

  item_t q_exp[$];
  int    n_run = 0;
  int    n_fail = 0;
  event  chk_ev;

  function automatic int fl(int r, int pct); return (r * pct) / 100; endfunction
  function automatic int cl(int r, int pct); return (r * pct + 99) / 100; endfunction

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (q_exp.size() > 0) begin
        item_t it;
        it = q_exp.pop_front();
        n_run++;
        if (!it.is_ov) begin
          if (pg_good !== it.ea || pg_irq !== it.eb) begin
            n_fail++;
            $display("FAIL %s: pg_good/pg_irq=%b/%b expected %b/%b", it.tag, pg_good, pg_irq, it.ea, it.eb);
          end
        end else begin
          if (ov_fault !== it.ea || freq_req !== it.eb) begin
            n_fail++;
            $display("FAIL %s: ov_fault/freq_req=%b/%b expected %b/%b", it.tag, ov_fault, freq_req, it.ea, it.eb);
          end
        end
      end
    end
  end

  task automatic exp_pg(input string tag, input bit g, input bit irq);
    item_t it;
    it.tag = tag; it.is_ov = 1'b0; it.ea = g; it.eb = irq;
    q_exp.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic exp_ov(input string tag, input bit f, input bit fr);
    item_t it;
    it.tag = tag; it.is_ov = 1'b1; it.ea = f; it.eb = fr;
    q_exp.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_sw(input int n);
    for (int i = 0; i < n; i++) begin
      sw_tick = 1'b1; cyc(1);
      sw_tick = 1'b0; cyc(1);
    end
  endtask

  task automatic pulse_clear();
    ov_clear = 1'b1; cyc(1);
    ov_clear = 1'b0; cyc(1);
  endtask

  task automatic pulse_ss();
    ss_done = 1'b1; cyc(1);
    ss_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sw_tick = 1'b0; slewing = 1'b0; ss_done = 1'b0;
    pg_mask = 1'b0; ov_mask = 1'b0; ov_clear = 1'b0;
    fb_code = '0; ref_code = 10'd200;
    cyc(3);
    exp_pg("R1 reset", 1'b0, 1'b1);
    exp_ov("R1 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    cyc(4);

    // R2: qualification time, one tick short then complete
    fb_code = 10'(cl(200, 95));
    cyc((Q - 1) * P);
    exp_pg("R2 short of qual", 1'b0, 1'b1);
    cyc(P);
    exp_pg("R2 qualified", 1'b1, 1'b0);

    // drop, then R3 restart
    fb_code = '0;
    tick_sw(2);
    exp_pg("R5 drop after two ticks", 1'b0, 1'b1);
    fb_code = 10'd200;
    cyc((Q - 2) * P);
    fb_code = '0;
    cyc(1);
    fb_code = 10'd200;
    cyc((Q - 1) * P);
    exp_pg("R3 restarted count", 1'b0, 1'b1);
    cyc(P);
    exp_pg("R3 qualified after restart", 1'b1, 1'b0);

    // R5: exit window hysteresis
    fb_code = 10'(fl(200, 107));
    tick_sw(3);
    exp_pg("R5 inside exit window", 1'b1, 1'b0);
    fb_code = 10'(fl(200, 107) + 1);
    tick_sw(1);
    exp_pg("R5 one tick outside", 1'b1, 1'b0);
    fb_code = 10'd200;
    tick_sw(1);
    fb_code = 10'(fl(200, 107) + 1);
    tick_sw(1);
    exp_pg("R5 count restarted on return", 1'b1, 1'b0);
    tick_sw(1);
    exp_pg("R5 R6 dropped, irq raised", 1'b0, 1'b1);

    // R7 mask
    pg_mask = 1'b1; cyc(1);
    exp_pg("R7 masked", 1'b1, 1'b0);
    pg_mask = 1'b0; cyc(1);
    exp_pg("R7 unmasked", 1'b0, 1'b1);

    // R4 rounding with ref 333: entry 317..349, exit 310..356
    ref_code = 10'd333;
    fb_code = 10'(cl(333, 95) - 1);
    cyc((Q + 2) * P);
    exp_pg("R4 below entry low bound", 1'b0, 1'b1);
    fb_code = 10'(fl(333, 105) + 1);
    cyc((Q + 2) * P);
    exp_pg("R4 above entry high bound", 1'b0, 1'b1);
    fb_code = 10'(fl(333, 105));
    cyc(Q * P);
    exp_pg("R4 at entry high bound", 1'b1, 1'b0);
    fb_code = 10'(cl(333, 93));
    tick_sw(3);
    exp_pg("R5 at exit low bound", 1'b1, 1'b0);
    fb_code = 10'(cl(333, 93) - 1);
    tick_sw(2);
    exp_pg("R5 below exit low bound", 1'b0, 1'b1);

    // R9: not armed from reset; threshold for 333 is 382
    fb_code = 10'(fl(333, 115) + 1);
    tick_sw(2);
    exp_ov("R9 unarmed after reset", 1'b0, 1'b0);
    pulse_ss();
    tick_sw(2);
    exp_ov("R9 inside arming delay", 1'b0, 1'b0);
    cyc(A * P);

    // R8 threshold and persistence
    fb_code = 10'(fl(333, 115));
    tick_sw(3);
    exp_ov("R8 equal to threshold", 1'b0, 1'b0);
    fb_code = 10'(fl(333, 115) + 1);
    tick_sw(1);
    exp_ov("R8 one tick above", 1'b0, 1'b0);
    tick_sw(1);
    exp_ov("R8 R11 fault set", 1'b1, 1'b1);

    // R10 latch
    pulse_clear();
    exp_ov("R10 clear while above ignored", 1'b1, 1'b1);
    fb_code = 10'd200;
    cyc(3);
    exp_ov("R10 holds without clear", 1'b1, 1'b1);
    pulse_clear();
    exp_ov("R10 cleared", 1'b0, 1'b0);

    // R12 mask
    ov_mask = 1'b1;
    fb_code = 10'd400;
    tick_sw(2);
    exp_ov("R12 masked no set", 1'b0, 1'b0);
    ov_mask = 1'b0; cyc(1);
    exp_ov("R12 unmask shows no fault", 1'b0, 1'b0);
    tick_sw(2);
    exp_ov("R12 R11 set after unmask", 1'b1, 1'b1);
    ov_mask = 1'b1; cyc(1);
    exp_ov("R12 latched fault hidden", 1'b0, 1'b0);
    ov_mask = 1'b0; cyc(1);
    exp_ov("R12 latched fault returns", 1'b1, 1'b1);
    fb_code = 10'd200;
    pulse_clear();
    exp_ov("R10 cleared again", 1'b0, 1'b0);

    // R9 slewing disarms until next soft-start completion
    slewing = 1'b1; cyc(2);
    slewing = 1'b0;
    fb_code = 10'd400;
    tick_sw(2);
    exp_ov("R9 disarmed by slewing", 1'b0, 1'b0);
    pulse_ss();
    tick_sw(2);
    exp_ov("R9 blanked during delay", 1'b0, 1'b0);
    cyc(A * P);
    tick_sw(2);
    exp_ov("R9 rearmed after delay", 1'b1, 1'b1);

    cyc(2);
    finish_run();
  end
endmodule